// File: doc/BRIEF.md
# Sigma-Delta Bitstream Decimation Converter

This block turns the one-bit output of an isolated sigma-delta modulator into 15-bit samples. The modulator supplies its own clock and data line. The block brings both lines into the system clock domain and captures one data bit at each rising edge of the modulator clock. A cascaded third-order sinc filter averages the captured bits. The filter output is then decimated, scaled and clipped to an offset-binary code.

A three-bit mode input selects one of five averaging lengths. Longer windows give finer resolution and a longer signal delay, and shorter windows answer faster. Each completed window produces a code with a one-cycle valid strobe. The code register keeps its value until the next sample. A change of the effective mode restarts the filter, and results are withheld until the filter history is complete again.

Top module: `sdm_decimator`

## Requirements
- R1: One modulator bit is taken per rising edge of `modClk`, using the level of `modData` at that edge after both lines pass through a common synchronizer. No bit is taken at falling edges.
- R2: With bits counted as 1 for high and 0 for low, each result is the third-order sinc sum y over the last window. The window length is R = 2^k captured bits. The code is floor(y * 2^15 / R^3).
- R3: A bit density of one half gives the midscale code 16384 (binary 100000000000000).
- R4: A stream of all ones gives 32767, the all-ones code. Any value that would reach 2^15 or more is clipped to 32767 and never wraps.
- R5: A stream of all zeros gives code 0.
- R6: `modeSel` values 1, 2, 3, 4 and 5 select decimation ratios of 1024, 512, 256, 128 and 64 bits. The values 0, 6 and 7 select the same ratio as mode 3, which is the default.
- R7: A change of the effective mode clears the filter and restarts window counting. The first three windows after the restart are discarded. The fourth and every later window produce a result.
- R8: A change of `modeSel` that leaves the effective mode unchanged (for example 3 to 7) does not restart the filter. Results continue one per window.
- R9: `sampleValid` is high for exactly one system clock per result. `sampleCode` changes only in the cycle in which `sampleValid` is high.
- R10: After reset, `sampleValid` is low and `sampleCode` holds midscale 16384.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| modClk | input | 1 | Clock line from the modulator (asynchronous) |
| modData | input | 1 | One-bit data line from the modulator |
| modeSel | input | 3 | Conversion mode select, 1 to 5; other values fall back to 3 |
| sampleCode | output | 15 | Offset-binary result, held between samples |
| sampleValid | output | 1 | One-cycle strobe marking a new result |

## Verification
The bench drives the rails: all ones must clip to 32767. A design that wraps the full-scale sum R^3 would show 0 instead. It also drives all zeros and an exactly alternating stream. That stream must land on 16384; a scaling shift off by one place would double or halve it. Random streams in every mode are compared with a direct convolution over the stored bits. This catches a ratio mapped to the wrong mode, an integrator chain that adds a pipeline delay, and a skipped or doubled bit capture. The bench counts results after each restart, so a design that lets the discarded windows through, or that restarts on a `modeSel` change with no effect, shows the wrong number of strobes.

// File: rtl/sdm_dec_pkg.sv
package sdm_dec_pkg;

  // Width of a mode index (0 = longest window)
  localparam int MODE_IDX_W = 3;

  // Strobes handed from control to datapath each system clock
  typedef struct packed {
    logic                  clear;    // restart filter state
    logic                  capture;  // a new modulator bit is present
    logic                  bitIn;    // value of that bit
    logic                  decim;    // this bit closes a window
    logic                  emit;     // publish the window result
    logic [MODE_IDX_W-1:0] modeIdx;  // active mode, 0 = longest window
  } ctrl_strobe_t;

endpackage

// File: rtl/sdm_dec_ctrl.sv
module sdm_dec_ctrl
  import sdm_dec_pkg::*;
#(
  parameter int LOG2_MAX     = 10,
  parameter int NUM_MODES    = 5,
  parameter int DEFAULT_MODE = 3,
  parameter int DISCARD      = 3,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  modClk,
  input  logic                  modData,
  input  logic [MODE_IDX_W-1:0] modeSel,
  output ctrl_strobe_t          strobes
);

  localparam int CNT_W  = LOG2_MAX;
  localparam int DISC_W = $clog2(DISCARD + 1);

  // Clock and data travel through matching synchronizer chains
  logic [SYNC_STAGES:0]   clkSync;
  logic [SYNC_STAGES-1:0] dataSync;
  logic                   modRise;
  logic                   syncBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkSync  <= '0;
      dataSync <= '0;
    end else begin
      clkSync  <= {clkSync[SYNC_STAGES-1:0], modClk};
      dataSync <= {dataSync[SYNC_STAGES-2:0], modData};
    end
  end

  assign modRise = clkSync[SYNC_STAGES-1] & ~clkSync[SYNC_STAGES];
  assign syncBit = dataSync[SYNC_STAGES-1];

  // Effective mode: legal values map directly, others fall back to default
  logic [MODE_IDX_W-1:0] reqIdx;
  logic [MODE_IDX_W-1:0] modeQ;
  logic                  modeChange;

  always_comb begin
    if (modeSel >= MODE_IDX_W'(1) && int'(modeSel) <= NUM_MODES)
      reqIdx = modeSel - MODE_IDX_W'(1);
    else
      reqIdx = MODE_IDX_W'(DEFAULT_MODE - 1);
  end

  assign modeChange = (reqIdx != modeQ);

  // Window bit counter and discard counter
  logic [CNT_W-1:0]  capCnt;
  logic [CNT_W-1:0]  winLimit;
  logic [DISC_W-1:0] discardCnt;
  logic              winEnd;

  assign winLimit = CNT_W'((1 << (LOG2_MAX - int'(modeQ))) - 1);
  assign winEnd   = modRise && !modeChange && (capCnt == winLimit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ      <= MODE_IDX_W'(DEFAULT_MODE - 1);
      capCnt     <= '0;
      discardCnt <= '0;
    end else if (modeChange) begin
      modeQ      <= reqIdx;
      capCnt     <= '0;
      discardCnt <= '0;
    end else if (modRise) begin
      if (capCnt == winLimit) begin
        capCnt <= '0;
        if (discardCnt != DISC_W'(DISCARD))
          discardCnt <= discardCnt + DISC_W'(1);
      end else begin
        capCnt <= capCnt + CNT_W'(1);
      end
    end
  end

  always_comb begin
    strobes.clear   = modeChange;
    strobes.capture = modRise && !modeChange;
    strobes.bitIn   = syncBit;
    strobes.decim   = winEnd;
    strobes.emit    = winEnd && (discardCnt == DISC_W'(DISCARD));
    strobes.modeIdx = modeQ;
  end

  // The bit counter never runs past the window of the active mode
  AST_COUNT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    capCnt <= winLimit);  // R6

  // The mode index always names one of the supported modes
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    int'(modeQ) < NUM_MODES);  // R6

  // A restart zeroes the window count and publishes nothing next cycle
  AST_CLEAR_RESTARTS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clear |=> (capCnt == '0) && !strobes.emit);  // R7

endmodule

// File: rtl/sdm_dec_datapath.sv
module sdm_dec_datapath
  import sdm_dec_pkg::*;
#(
  parameter int LOG2_MAX = 10,
  parameter int ORDER    = 3,
  parameter int OUT_W    = 15
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_strobe_t     strobes,
  output logic [OUT_W-1:0] sampleCode,
  output logic             sampleValid
);

  // Exact comb output needs ORDER*log2(max ratio)+1 bits
  localparam int ACC_W = ORDER * LOG2_MAX + 1;
  localparam int SH_W  = $clog2(ACC_W + 1);
  localparam logic [OUT_W-1:0] MIDSCALE = OUT_W'(1) << (OUT_W - 1);

  logic [ACC_W-1:0] intQ  [ORDER];
  logic [ACC_W-1:0] intN  [ORDER];
  logic [ACC_W-1:0] combD [ORDER];
  logic [ACC_W-1:0] combV [ORDER+1];
  logic [ACC_W-1:0] combOut;

  // Integrator chain, evaluated without pipeline delay between stages
  always_comb begin
    intN[0] = intQ[0] + ACC_W'(strobes.bitIn);
    for (int s = 1; s < ORDER; s++)
      intN[s] = intQ[s] + intN[s-1];
  end

  // Comb chain on the newest integrator value
  always_comb begin
    combV[0] = intN[ORDER-1];
    for (int s = 0; s < ORDER; s++)
      combV[s+1] = combV[s] - combD[s];
  end

  assign combOut = combV[ORDER];

  generate
    for (genvar g = 0; g < ORDER; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rstN || strobes.clear) begin
          intQ[g]  <= '0;
          combD[g] <= '0;
        end else if (strobes.capture) begin
          intQ[g] <= intN[g];
          if (strobes.decim)
            combD[g] <= combV[g];
        end
      end
    end
  endgenerate

  // Scaling to the output width, with clipping at the upper rail
  logic [SH_W-1:0]  shiftAmt;
  logic [ACC_W-1:0] scaled;
  logic [ACC_W-1:0] fullScale;
  logic [OUT_W-1:0] codeNext;

  always_comb begin
    shiftAmt  = SH_W'(ORDER * (LOG2_MAX - int'(strobes.modeIdx)) - OUT_W);
    fullScale = ACC_W'(1) << (ORDER * (LOG2_MAX - int'(strobes.modeIdx)));
    scaled    = combOut >> shiftAmt;
    if (|scaled[ACC_W-1:OUT_W])
      codeNext = '1;
    else
      codeNext = scaled[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleCode  <= MIDSCALE;
      sampleValid <= 1'b0;
    end else begin
      sampleValid <= strobes.emit;
      if (strobes.emit)
        sampleCode <= codeNext;
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid);  // R9

  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |-> $stable(sampleCode));  // R9

  AST_FULL_SCALE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    strobes.emit |-> combOut <= fullScale);  // R2

  AST_RAIL_CLIPS: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.emit && combOut == fullScale) |=> sampleCode == '1);  // R4

endmodule

// File: rtl/sdm_decimator.sv
module sdm_decimator
  import sdm_dec_pkg::*;
#(
  parameter int LOG2_MAX     = 10,
  parameter int NUM_MODES    = 5,
  parameter int DEFAULT_MODE = 3,
  parameter int DISCARD      = 3,
  parameter int ORDER        = 3,
  parameter int OUT_W        = 15
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modClk,
  input  logic             modData,
  input  logic [2:0]       modeSel,
  output logic [OUT_W-1:0] sampleCode,
  output logic             sampleValid
);

  ctrl_strobe_t strobes;

  sdm_dec_ctrl #(
    .LOG2_MAX    (LOG2_MAX),
    .NUM_MODES   (NUM_MODES),
    .DEFAULT_MODE(DEFAULT_MODE),
    .DISCARD     (DISCARD),
    .SYNC_STAGES (2)
  ) i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .modClk (modClk),
    .modData(modData),
    .modeSel(modeSel),
    .strobes(strobes)
  );

  sdm_dec_datapath #(
    .LOG2_MAX(LOG2_MAX),
    .ORDER   (ORDER),
    .OUT_W   (OUT_W)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .sampleCode (sampleCode),
    .sampleValid(sampleValid)
  );

endmodule

// File: tb/test_sdm_decimator.sv
module test_sdm_decimator;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_BITS   = 8192;
  localparam int MAX_OUT    = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modClk = 1'b0;
  logic        modData = 1'b0;
  logic [2:0]  modeSel = 3'd3;
  logic [14:0] sampleCode;
  logic        sampleValid;

  sdm_decimator i_sdm_decimator (
    .clk(clk), .rstN(rstN), .modClk(modClk), .modData(modData),
    .modeSel(modeSel), .sampleCode(sampleCode), .sampleValid(sampleValid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int     nChecks = 0;
  int     nFail   = 0;
  bit     done    = 0;
  bit     bitsArr [MAX_BITS];
  int     bitCnt  = 0;
  int     gotCode [MAX_OUT];
  int     gotCnt  = 0;
  int     r9Viol  = 0;
  longint kern    [3072];

  task automatic check(bit ok, string req, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Output monitor, sampled away from the active edge (R9)
  logic        prevValid = 1'b0;
  logic [14:0] prevCode  = 15'h4000;
  always @(negedge clk) begin
    if (rstN) begin
      if (sampleValid) begin
        if (gotCnt < MAX_OUT) gotCode[gotCnt] = int'(sampleCode);
        gotCnt++;
        if (prevValid) r9Viol++;
      end else if (sampleCode != prevCode) begin
        r9Viol++;
      end
    end
    prevValid = sampleValid;
    prevCode  = sampleCode;
  end

  // Kernel of three cascaded length-R boxcars
  function automatic void buildKernel(int r);
    int triLen = 2*r - 1;
    for (int j = 0; j <= 3*r - 3; j++) begin
      longint acc = 0;
      int lo = (j - r + 1 > 0) ? j - r + 1 : 0;
      int hi = (j < triLen - 1) ? j : triLen - 1;
      for (int i = lo; i <= hi; i++)
        acc += (i < r) ? longint'(i + 1) : longint'(triLen - i);
      kern[j] = acc;
    end
  endfunction

  function automatic int expectCode(int r, int lg, int endIdx);
    longint y = 0;
    longint sc;
    for (int j = 0; j <= 3*r - 3; j++)
      if (endIdx - j >= 0 && bitsArr[endIdx - j]) y += kern[j];
    sc = y >>> (3*lg - 15);
    return (sc > 32767) ? 32767 : int'(sc);
  endfunction

  // One modulator bit: data placed while clock is low, then clock rises
  task automatic driveBit(bit b);
    @(negedge clk);
    modClk  = 1'b0;
    modData = b;
    bitsArr[bitCnt] = b;
    bitCnt++;
    @(negedge clk);
    @(negedge clk);
    modClk = 1'b1;
    @(negedge clk);
  endtask

  // kind: 0 random with pct percent ones, 1 alternating, 2 ones, 3 zeros
  task automatic feed(int nBits, int kind, int pct);
    for (int i = 0; i < nBits; i++) begin
      bit b;
      case (kind)
        0: b = ($urandom % 100) < pct;
        1: b = (bitCnt % 2) == 0;
        2: b = 1'b1;
        default: b = 1'b0;
      endcase
      driveBit(b);
    end
    repeat (12) @(negedge clk);
  endtask

  task automatic startRun(int m);
    modeSel = 3'(m);
    repeat (8) @(negedge clk);
    bitCnt = 0;
    gotCnt = 0;
  endtask

  // Compare results for windows nFrom..nTo, result k belongs to window k+4
  task automatic checkRun(string req, int r, int lg, int nFrom, int nTo);
    buildKernel(r);
    check(gotCnt == nTo - 3, {req, " result count"}, gotCnt, nTo - 3);
    for (int n = nFrom; n <= nTo; n++) begin
      int exp = expectCode(r, lg, n*r - 1);
      int act = (n - 4 < gotCnt && n - 4 < MAX_OUT) ? gotCode[n-4] : -1;
      check(act == exp, req, act, exp);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    // R10: reset state
    check(sampleValid == 1'b0, "R10 valid in reset", sampleValid, 0);
    check(sampleCode == 15'd16384, "R10 code in reset", sampleCode, 16384);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check(sampleCode == 15'd16384, "R10 code after reset", sampleCode, 16384);

    // R3 and R7: alternating stream in default mode 3, six windows
    startRun(3);
    feed(6*256, 1, 0);
    checkRun("R3 R7 midscale mode 3", 256, 8, 4, 6);

    // R8: 3 -> 7 keeps mode 3, results continue without a restart
    modeSel = 3'd7;
    feed(2*256, 1, 0);
    checkRun("R8 no restart on equivalent mode", 256, 8, 4, 8);

    // R4: all ones in mode 5 clips to the all-ones code
    startRun(5);
    feed(6*64, 2, 0);
    checkRun("R4 ones clip", 64, 6, 4, 6);

    // R5: all zeros in mode 2
    startRun(2);
    feed(6*512, 3, 0);
    checkRun("R5 zeros", 512, 9, 4, 6);

    // R1 R2 R6: random streams in every mode
    startRun(4);
    feed(6*128, 0, 97);
    checkRun("R1 R2 R6 random mode 4", 128, 7, 4, 6);
    startRun(1);
    feed(6*1024, 0, 30);
    checkRun("R1 R2 R6 random mode 1", 1024, 10, 4, 6);
    startRun(3);
    feed(6*256, 0, 55);
    checkRun("R1 R2 R6 random mode 3", 256, 8, 4, 6);
    startRun(5);
    feed(6*64, 0, 12);
    checkRun("R1 R2 R6 random mode 5", 64, 6, 4, 6);
    startRun(2);
    feed(6*512, 0, 70);
    checkRun("R1 R2 R6 random mode 2", 512, 9, 4, 6);

    // R6: out-of-range value 0 falls back to mode 3 (ratio 256), restart from mode 2
    startRun(0);
    feed(5*256, 0, 45);
    checkRun("R6 R7 fallback mode", 256, 8, 4, 5);

    // R9: strobe width and code holding over the whole run
    check(r9Viol == 0, "R9 strobe and hold", r9Viol, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

endmodule